// File: doc/BRIEF.md
# GPIO Port Pin-Function Register Bank

This block holds the pin configuration for several GPIO ports of 32 pins each. For every pin it stores an interrupt-select bit, a mask bit, two pattern bits, a flag bit and a pull-disable bit. From the four mode bits it works out whether the pin is a GPIO input, a GPIO output, an interrupt input, or one of four peripheral functions. It drives the resulting function-select, output-enable, output-level and pull signals to the pad ring. It also lets software read back the live pad input levels.

Software reaches the bank over a plain 32-bit register bus with word addresses. Each port has its own 0x100-byte window. No control register can be written directly. Each one has a set alias and a clear alias, so that a single write changes only the pins whose data bits are one. This lets two drivers that own different pins of the same port share the port without a read-modify-write race.

Pull resistors exist only on pins listed in two fixed per-port capability masks, one for pull-up and one for pull-down. The pull-disable bits of pins with no capability are held at one.

Top module: `gpio_pinfunc_bank`

## Requirements
- R1: After reset, every pin is a GPIO input. Its registers read as follows: interrupt-select 0, mask all ones, pattern-1 all ones, pattern-0 0, flag 0, and pull-disable equal to the inverse of (pull-up capability OR pull-down capability). No pad has output enable or function enable asserted.
- R2: A register of port p sits at p*0x100 plus its offset. The offsets are: pin data 0x00 (read-only, the pad_in levels of the port), interrupt-select 0x10, mask 0x20, pattern-1 0x30, pattern-0 0x40, flag 0x50 and pull-disable 0x70. Read data appears on bus_rdata in the cycle after the read request and holds until the next read.
- R3: A write to a register offset plus 0x4 sets every bit written as one and leaves the other bits unchanged.
- R4: A write to a register offset plus 0x8 clears every bit written as one and leaves the other bits unchanged.
- R5: A write to a plain register offset, or to any address of the pin-data register, has no effect. A read of a set or clear alias returns the current register value.
- R6: An address whose offset is not one of those named in R2, R3 and R4, or whose port index (address bits 8 and up) is NUM_PORTS or more, reads as zero and ignores writes.
- R7: A pin whose interrupt-select bit and mask bit are both 0 is in peripheral mode. Its pad_func_en is 1, its two-bit pad_func_sel is {pattern-1, pattern-0}, and its output enable is 0.
- R8: A pin whose interrupt-select bit is 0 and mask bit is 1 is GPIO. Pattern-1 equal to 1 makes it an input (pad_oe 0). Pattern-1 equal to 0 makes it an output (pad_oe 1), and pad_out then follows pattern-0.
- R9: A pin whose interrupt-select bit is 1 is an interrupt input. Its pad_func_en, pad_func_sel, pad_oe and pad_out are all 0.
- R10: A pull-disable bit of 0 enables the pull. pad_pull_en is 1 only for a pin that has the pull enabled and is pull-up or pull-down capable. pad_pull_up marks an enabled pull on an up-capable pin. pad_pull_dn marks an enabled pull on a pin that is down-capable and not up-capable. The pull-disable bits of pins with no capability read 1 whatever is written.
- R11: An access to one port changes no register or pad output of any other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: port index in the upper bits, offset in bits 7:0 |
| bus_wdata | input | 32 | Write data (bit mask for the set and clear aliases) |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32*NUM_PORTS | Live pad input levels |
| pad_func_en | output | 32*NUM_PORTS | Pin is routed to a peripheral |
| pad_func_sel | output | 64*NUM_PORTS | Peripheral function number, two bits per pin |
| pad_oe | output | 32*NUM_PORTS | GPIO output enable |
| pad_out | output | 32*NUM_PORTS | GPIO output level |
| pad_pull_en | output | 32*NUM_PORTS | Pull resistor enabled |
| pad_pull_up | output | 32*NUM_PORTS | Enabled pull is a pull-up |
| pad_pull_dn | output | 32*NUM_PORTS | Enabled pull is a pull-down |

## Verification
Two things can happen in the same cycle: a set or clear write, and the capability masking of the pull register. The bench provokes this with one set-all and one clear write whose bit mask covers capable and non-capable pins alike. It then judges the result from the register read-back and from the pull pad outputs. Mode decode and a register write also coincide: changing one bit of the mask, pattern or interrupt register moves a pin between modes. The bench checks the pad outputs of the affected pins, and of their neighbours, in the cycle after the write.

// File: rtl/gpio_pf_pkg.sv
package gpio_pf_pkg;
  localparam int PORT_PINS = 32;
  localparam int WIN_BITS  = 8;
  localparam int NUM_CTL   = 6;

  // address bits 7:4 select the register inside a port window
  localparam logic [3:0] RSEL_DATA = 4'h0;
  localparam logic [3:0] RSEL_INT  = 4'h1;
  localparam logic [3:0] RSEL_MASK = 4'h2;
  localparam logic [3:0] RSEL_PAT1 = 4'h3;
  localparam logic [3:0] RSEL_PAT0 = 4'h4;
  localparam logic [3:0] RSEL_FLAG = 4'h5;
  localparam logic [3:0] RSEL_PULL = 4'h7;

  // storage index of each control register
  localparam logic [2:0] CTL_INT  = 3'd0;
  localparam logic [2:0] CTL_MASK = 3'd1;
  localparam logic [2:0] CTL_PAT1 = 3'd2;
  localparam logic [2:0] CTL_PAT0 = 3'd3;
  localparam logic [2:0] CTL_FLAG = 3'd4;
  localparam logic [2:0] CTL_PULL = 3'd5;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } acc_op_e;
endpackage

// File: rtl/gpio_pf_addr_dec.sv
module gpio_pf_addr_dec
  import gpio_pf_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int PIDX_W    = 3,
  parameter int ADDR_W    = 11
) (
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_PORTS-1:0] port_hit,
  output logic [PIDX_W-1:0]    port_idx,
  output logic [2:0]           ctl_idx,
  output logic                 acc_ctl,
  output logic                 acc_data,
  output logic                 wr_set,
  output logic                 wr_clr
);
  logic [3:0] rsel;
  logic [3:0] osel;
  logic       port_ok;
  logic       ctl_ok;
  acc_op_e    op;

  assign rsel     = addr[7:4];
  assign osel     = addr[3:0];
  assign port_idx = addr[ADDR_W-1:WIN_BITS];
  assign port_ok  = port_idx < PIDX_W'(NUM_PORTS);

  always_comb begin
    case (osel)
      4'h0:    op = OP_PLAIN;
      4'h4:    op = OP_SET;
      4'h8:    op = OP_CLR;
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    ctl_ok  = 1'b1;
    ctl_idx = CTL_INT;
    case (rsel)
      RSEL_INT:  ctl_idx = CTL_INT;
      RSEL_MASK: ctl_idx = CTL_MASK;
      RSEL_PAT1: ctl_idx = CTL_PAT1;
      RSEL_PAT0: ctl_idx = CTL_PAT0;
      RSEL_FLAG: ctl_idx = CTL_FLAG;
      RSEL_PULL: ctl_idx = CTL_PULL;
      default:   ctl_ok  = 1'b0;
    endcase
  end

  assign acc_ctl  = port_ok && ctl_ok && (op != OP_NONE);
  assign acc_data = port_ok && (rsel == RSEL_DATA) && (op != OP_NONE);
  assign wr_set   = req && we && acc_ctl && (op == OP_SET);
  assign wr_clr   = req && we && acc_ctl && (op == OP_CLR);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    assign port_hit[p] = port_ok && (port_idx == PIDX_W'(p));
  end
endmodule

// File: rtl/gpio_pf_setclr_reg.sv
module gpio_pf_setclr_reg #(
  parameter int         W          = 32,
  parameter logic [W-1:0] RST_VAL    = '0,
  parameter logic [W-1:0] FIXED_ONES = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (clr_en) nxt = nxt & ~wdata;
    if (set_en) nxt = nxt | wdata;
    nxt = nxt | FIXED_ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= RST_VAL | FIXED_ONES;
    else if (set_en || clr_en) q <= nxt;
  end
endmodule

// File: rtl/gpio_pf_pin_dec.sv
module gpio_pf_pin_dec #(
  parameter bit PU_OK = 1'b1,
  parameter bit PD_OK = 1'b0
) (
  input  logic       intr,
  input  logic       mask,
  input  logic       pat1,
  input  logic       pat0,
  input  logic       pull_dis,
  output logic       func_en,
  output logic [1:0] func_sel,
  output logic       oe,
  output logic       out,
  output logic       pull_en,
  output logic       pull_up,
  output logic       pull_dn
);
  localparam bit CAP = PU_OK || PD_OK;

  always_comb begin
    func_en  = !intr && !mask;
    func_sel = func_en ? {pat1, pat0} : 2'b00;
    oe       = !intr && mask && !pat1;
    out      = oe && pat0;
    pull_en  = !pull_dis && CAP;
    pull_up  = pull_en && PU_OK;
    pull_dn  = pull_en && PD_OK && !PU_OK;
  end
endmodule

// File: rtl/gpio_pf_port.sv
module gpio_pf_port
  import gpio_pf_pkg::*;
#(
  parameter logic [31:0] PU_MASK = 32'hFFFF_FFFF,
  parameter logic [31:0] PD_MASK = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr_set,
  input  logic        wr_clr,
  input  logic [2:0]  ctl_idx,
  input  logic [31:0] wdata,
  output logic [31:0] rd_ctl,
  output logic [31:0] func_en,
  output logic [63:0] func_sel,
  output logic [31:0] oe,
  output logic [31:0] out,
  output logic [31:0] pull_en,
  output logic [31:0] pull_up,
  output logic [31:0] pull_dn
);
  localparam logic [31:0] CAP = PU_MASK | PD_MASK;

  function automatic logic [31:0] reset_of(input int i);
    case (i)
      int'(CTL_MASK), int'(CTL_PAT1): return 32'hFFFF_FFFF;
      int'(CTL_PULL):                 return ~CAP;
      default:                        return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fixed_of(input int i);
    return (i == int'(CTL_PULL)) ? ~CAP : 32'h0;
  endfunction

  logic [31:0] ctl_q [NUM_CTL];

  for (genvar r = 0; r < NUM_CTL; r++) begin : g_reg
    gpio_pf_setclr_reg #(
      .W(32), .RST_VAL(reset_of(r)), .FIXED_ONES(fixed_of(r))
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (sel && wr_set && (ctl_idx == 3'(r))),
      .clr_en (sel && wr_clr && (ctl_idx == 3'(r))),
      .wdata  (wdata),
      .q      (ctl_q[r])
    );
  end

  always_comb begin
    rd_ctl = '0;
    for (int r = 0; r < NUM_CTL; r++)
      if (ctl_idx == 3'(r)) rd_ctl = ctl_q[r];
  end

  for (genvar b = 0; b < PORT_PINS; b++) begin : g_pin
    gpio_pf_pin_dec #(.PU_OK(PU_MASK[b]), .PD_OK(PD_MASK[b])) u_dec (
      .intr     (ctl_q[CTL_INT][b]),
      .mask     (ctl_q[CTL_MASK][b]),
      .pat1     (ctl_q[CTL_PAT1][b]),
      .pat0     (ctl_q[CTL_PAT0][b]),
      .pull_dis (ctl_q[CTL_PULL][b]),
      .func_en  (func_en[b]),
      .func_sel (func_sel[2*b +: 2]),
      .oe       (oe[b]),
      .out      (out[b]),
      .pull_en  (pull_en[b]),
      .pull_up  (pull_up[b]),
      .pull_dn  (pull_dn[b])
    );
  end
endmodule

// File: rtl/gpio_pinfunc_bank.sv
module gpio_pinfunc_bank
  import gpio_pf_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter logic [NUM_PORTS*32-1:0] PU_CAP = {NUM_PORTS{32'hFFFF_00FF}},
  parameter logic [NUM_PORTS*32-1:0] PD_CAP = {NUM_PORTS{32'h0000_0F00}},
  localparam int PIDX_W = $clog2(NUM_PORTS + 1),
  localparam int ADDR_W = WIN_BITS + PIDX_W,
  localparam int NPINS  = NUM_PORTS * PORT_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_func_en,
  output logic [2*NPINS-1:0] pad_func_sel,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pull_en,
  output logic [NPINS-1:0]  pad_pull_up,
  output logic [NPINS-1:0]  pad_pull_dn
);
  logic [NUM_PORTS-1:0] port_hit;
  logic [PIDX_W-1:0]    port_idx;
  logic [2:0]           ctl_idx;
  logic                 acc_ctl;
  logic                 acc_data;
  logic                 wr_set;
  logic                 wr_clr;
  logic [31:0]          port_rd  [NUM_PORTS];
  logic [31:0]          port_pin [NUM_PORTS];
  logic [31:0]          rd_word;

  gpio_pf_addr_dec #(
    .NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .req      (bus_req),
    .we       (bus_we),
    .addr     (bus_addr),
    .port_hit (port_hit),
    .port_idx (port_idx),
    .ctl_idx  (ctl_idx),
    .acc_ctl  (acc_ctl),
    .acc_data (acc_data),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_pin[p] = pad_in[p*PORT_PINS +: PORT_PINS];

    gpio_pf_port #(
      .PU_MASK(PU_CAP[p*32 +: 32]), .PD_MASK(PD_CAP[p*32 +: 32])
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (port_hit[p]),
      .wr_set   (wr_set),
      .wr_clr   (wr_clr),
      .ctl_idx  (ctl_idx),
      .wdata    (bus_wdata),
      .rd_ctl   (port_rd[p]),
      .func_en  (pad_func_en[p*32 +: 32]),
      .func_sel (pad_func_sel[p*64 +: 64]),
      .oe       (pad_oe[p*32 +: 32]),
      .out      (pad_out[p*32 +: 32]),
      .pull_en  (pad_pull_en[p*32 +: 32]),
      .pull_up  (pad_pull_up[p*32 +: 32]),
      .pull_dn  (pad_pull_dn[p*32 +: 32])
    );
  end

  // read path: one-hot port select, then control or pin-data word
  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_hit[p] && acc_ctl)  rd_word = rd_word | port_rd[p];
      if (port_hit[p] && acc_data) rd_word = rd_word | port_pin[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_req && !bus_we) bus_rdata <= rd_word;
  end

  logic unused_idx;
  assign unused_idx = ^port_idx;
endmodule

// File: rtl/gpio_pinfunc_bank_chk.sv
module gpio_pinfunc_bank_chk #(
  parameter int NUM_PORTS = 6,
  parameter int ADDR_W    = 11,
  parameter logic [NUM_PORTS*32-1:0] PU_CAP = '0,
  parameter logic [NUM_PORTS*32-1:0] PD_CAP = '0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_req,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [31:0]             bus_rdata,
  input logic [NUM_PORTS*32-1:0] pad_func_en,
  input logic [NUM_PORTS*32-1:0] pad_oe,
  input logic [NUM_PORTS*32-1:0] pad_out,
  input logic [NUM_PORTS*32-1:0] pad_pull_en,
  input logic [NUM_PORTS*32-1:0] pad_pull_up,
  input logic [NUM_PORTS*32-1:0] pad_pull_dn
);
  localparam int PW = ADDR_W - 8;
  localparam logic [NUM_PORTS*32-1:0] CAP = PU_CAP | PD_CAP;

  logic oob_wr;
  logic plain_wr;
  assign oob_wr   = bus_req && bus_we && (bus_addr[ADDR_W-1:8] >= PW'(NUM_PORTS));
  assign plain_wr = bus_req && bus_we && (bus_addr[3:0] == 4'h0);

  // R7: a pin never drives as GPIO output while routed to a peripheral
  a_r7_func_not_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_func_en & pad_oe) == '0);

  // R8: output level only on enabled GPIO outputs
  a_r8_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R10: pulls only on capable pins, up and down never together
  a_r10_pull_capable: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_en & ~CAP) == '0);
  a_r10_pull_kind: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_up & pad_pull_dn) == '0) && ((pad_pull_up | pad_pull_dn) == pad_pull_en));

  // R6: writes beyond the last port change nothing
  a_r6_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    oob_wr |=> $stable(pad_oe) && $stable(pad_func_en) && $stable(pad_pull_en));

  // R5: plain-offset writes change nothing
  a_r5_plain_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    plain_wr |=> $stable(pad_oe) && $stable(pad_func_en) && $stable(pad_pull_en));

  // R2: read data holds between reads
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> $stable(bus_rdata));
endmodule

bind gpio_pinfunc_bank gpio_pinfunc_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PU_CAP(PU_CAP), .PD_CAP(PD_CAP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .pad_func_en (pad_func_en),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out),
  .pad_pull_en (pad_pull_en),
  .pad_pull_up (pad_pull_up),
  .pad_pull_dn (pad_pull_dn)
);

// File: tb/gpio_pinfunc_bank_bench.sv
module gpio_pinfunc_bank_bench;
  localparam int NP = 6;
  localparam int AW = 11;
  localparam int NPIN = NP * 32;
  localparam int NV = 30;

  // {write, addr[10:0], data/expect[31:0], requirement number}
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 11'h120, 32'hFFFF_FFFF, 4'd1},   // R1 mask reset
    {1'b0, 11'h110, 32'h0000_0000, 4'd1},   // R1 interrupt reset
    {1'b0, 11'h170, 32'h0000_F000, 4'd10},  // R10 pull reset, pins 12-15 fixed
    {1'b0, 11'h130, 32'hFFFF_FFFF, 4'd1},   // R1 pattern-1 reset
    {1'b1, 11'h128, 32'h0000_000F, 4'd4},   // R4 clear mask 0-3
    {1'b0, 11'h120, 32'hFFFF_FFF0, 4'd4},
    {1'b1, 11'h144, 32'h0000_0005, 4'd3},   // R3 set pattern-0
    {1'b0, 11'h140, 32'h0000_0005, 4'd3},
    {1'b1, 11'h144, 32'h0000_0004, 4'd3},   // R3 zeros leave bits
    {1'b0, 11'h140, 32'h0000_0005, 4'd3},
    {1'b0, 11'h148, 32'h0000_0005, 4'd5},   // R5 alias read
    {1'b1, 11'h130, 32'h0000_0000, 4'd5},   // R5 plain write
    {1'b0, 11'h134, 32'hFFFF_FFFF, 4'd5},
    {1'b1, 11'h174, 32'hFFFF_FFFF, 4'd10},  // R10 disable all pulls
    {1'b0, 11'h170, 32'hFFFF_FFFF, 4'd10},
    {1'b1, 11'h178, 32'h0000_FF00, 4'd10},  // R10 clear incl. fixed pins
    {1'b0, 11'h170, 32'hFFFF_F0FF, 4'd10},
    {1'b1, 11'h1C4, 32'h0000_FFFF, 4'd6},   // R6 undefined offset
    {1'b0, 11'h1C0, 32'h0000_0000, 4'd6},
    {1'b1, 11'h164, 32'hFFFF_FFFF, 4'd6},   // R6 hole at 0x60
    {1'b0, 11'h160, 32'h0000_0000, 4'd6},
    {1'b1, 11'h614, 32'hFFFF_FFFF, 4'd6},   // R6 port beyond count
    {1'b0, 11'h610, 32'h0000_0000, 4'd6},
    {1'b0, 11'h020, 32'hFFFF_FFFF, 4'd11},  // R11 port 0 untouched
    {1'b1, 11'h238, 32'h0000_00FF, 4'd8},   // R8 port 2 outputs
    {1'b0, 11'h230, 32'hFFFF_FF00, 4'd8},
    {1'b0, 11'h130, 32'hFFFF_FFFF, 4'd11},  // R11 port 1 untouched
    {1'b1, 11'h554, 32'h0000_00A5, 4'd2},   // R2 flag offset
    {1'b1, 11'h558, 32'h0000_0005, 4'd4},   // R4 flag clear
    {1'b0, 11'h550, 32'h0000_00A0, 4'd2}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NPIN-1:0]   pad_in = '0;
  logic [NPIN-1:0]   pad_func_en;
  logic [2*NPIN-1:0] pad_func_sel;
  logic [NPIN-1:0]   pad_oe;
  logic [NPIN-1:0]   pad_out;
  logic [NPIN-1:0]   pad_pull_en;
  logic [NPIN-1:0]   pad_pull_up;
  logic [NPIN-1:0]   pad_pull_dn;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_pinfunc_bank u_gpio_pinfunc_bank (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_func_en(pad_func_en), .pad_func_sel(pad_func_sel),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [47:0] v;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10 reset pad state
    chk("R1 pad_oe", 256'(pad_oe), 256'(0));
    chk("R1 pad_func_en", 256'(pad_func_en), 256'(0));
    chk("R10 reset pull_en", 256'(pad_pull_en), 256'({NP{32'hFFFF_0FFF}}));
    chk("R10 reset pull_up", 256'(pad_pull_up), 256'({NP{32'hFFFF_00FF}}));
    chk("R10 reset pull_dn", 256'(pad_pull_dn), 256'({NP{32'h0000_0F00}}));

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[47]) bus_write(v[46:36], v[35:4]);
      else begin
        bus_read(v[46:36], rd);
        chk($sformatf("R%0d vector %0d", v[3:0], i), 256'(rd), 256'(v[35:4]));
      end
    end

    // R7 port 1 pins 0-3 peripheral, functions 3,2,3,2
    chk("R7 func_en", 256'(pad_func_en[63:32]), 256'(32'h0000_000F));
    chk("R7 func_sel", 256'(pad_func_sel[127:64]), 256'(64'hBB));
    chk("R7 no oe", 256'(pad_oe[63:32]), 256'(0));
    // R10 port 1 pulls on pins 8-11 only, down-capable
    chk("R10 pull_en p1", 256'(pad_pull_en[63:32]), 256'(32'h0000_0F00));
    chk("R10 pull_dn p1", 256'(pad_pull_dn[63:32]), 256'(32'h0000_0F00));
    chk("R10 pull_up p1", 256'(pad_pull_up[63:32]), 256'(0));
    // R11 port 0 pads untouched
    chk("R11 port0 func", 256'(pad_func_en[31:0]), 256'(0));
    chk("R11 port0 pull", 256'(pad_pull_en[31:0]), 256'(32'hFFFF_0FFF));
    // R8 port 2 GPIO outputs
    chk("R8 oe", 256'(pad_oe[95:64]), 256'(32'h0000_00FF));
    chk("R8 out low", 256'(pad_out[95:64]), 256'(0));
    bus_write(11'h244, 32'h1);
    chk("R8 out follows pat0", 256'(pad_out[95:64]), 256'(32'h1));
    // R9 interrupt mode
    bus_write(11'h214, 32'h1);
    chk("R9 oe drop", 256'(pad_oe[95:64]), 256'(32'h0000_00FE));
    chk("R9 out drop", 256'(pad_out[95:64]), 256'(0));
    bus_write(11'h114, 32'h1);
    chk("R9 func drop", 256'(pad_func_en[63:32]), 256'(32'h0000_000E));
    chk("R9 sel zero", 256'(pad_func_sel[127:64]), 256'(64'hB8));

    // R2 / R5 pin data read-back
    pad_in[127:96] = 32'hC0DE_1234;
    bus_read(11'h300, rd);
    chk("R2 pin data", 256'(rd), 256'(32'hC0DE_1234));
    bus_read(11'h308, rd);
    chk("R5 pin data alias", 256'(rd), 256'(32'hC0DE_1234));
    bus_write(11'h304, 32'hFFFF_FFFF);
    chk("R5 data write no pads", 256'(pad_oe[127:96]), 256'(0));
    bus_read(11'h300, rd);
    chk("R5 data write ignored", 256'(rd), 256'(32'hC0DE_1234));

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule